// File: doc/BRIEF.md
# Drum-Timed Instruction Phase Sequencer

This block is the bit-serial control sequencer of a drum-memory machine. It handles one binary digit per clock, and 32 digits make one word period. It steps the machine through four repeating phases: seek the instruction word, read it, seek the operand word, and execute. It advances only on the last digit of a word. A search phase ends once the sector number that the drum announces for the coming word agrees with the wanted address. That agreement is found by a serial compare over the six sector-field digits.

While it searches, the sequencer shifts the six track-field digits of the wanted address into a track-select register. In the operand search it also shifts the four order digits into an order register. One stage of that register is the run bit: when the run bit is clear, the instruction seek never ends, so the machine is held. An external start pulse sets the run bit again. During the instruction read, the sequencer adds one to the recirculating program-counter address field. The digits go in least significant first and come back out on a serial output.

The surrounding logic supplies the timing windows, the announced sector digits, and the serial counter and instruction-register digits. The drum, the arithmetic and the long multiply and divide phases are outside this block.

Top module: `drum_phase_seq`

States: `PH_SEEK_INSTR` (2'b00), `PH_READ_INSTR` (2'b01), `PH_SEEK_OPND` (2'b10), `PH_EXECUTE` (2'b11). Transitions, all taken only on a cycle with `t_strobe` high:
- `PH_SEEK_INSTR` to `PH_READ_INSTR`: taken when the search flag is armed and the run bit is 1.
- `PH_READ_INSTR` to `PH_SEEK_OPND`: always taken.
- `PH_SEEK_OPND` to `PH_EXECUTE`: taken when the search flag is armed.
- `PH_EXECUTE` to `PH_SEEK_INSTR`: always taken.

## Requirements
- R1: A synchronous active-high `rst` sets `phase` to 2'b00, `blocked` to 1, and `track_sel` and `order_reg` to zero. It also clears the search flag, so the first word after reset can never end a search.
- R2: `phase` encodes seek-instruction as 2'b00, read-instruction as 2'b01, seek-operand as 2'b10 and execute as 2'b11. It changes only on the clock edge that closes a cycle with `t_strobe` high.
- R3: Read-instruction always lasts exactly one word and is followed by seek-operand. Execute always lasts exactly one word and is followed by seek-instruction.
- R4: Seek-instruction ends at the `t_strobe` of a word in which the previous word ended with `t_strobe`, the run bit is 1, and, in every `u_win` cycle, `ann_digit` equalled `pc_digit`. The next word is read-instruction. Any mismatch keeps the phase at 2'b00.
- R5: Seek-operand ends under the same rule, with `ir_digit` compared in place of `pc_digit`. The next word is execute.
- R6: `blocked` equals the inverse of the run bit `order_reg[1]`. While it is 1, seek-instruction does not end, even on a full sector match. `start_pulse` sets `order_reg[1]` on the next edge, except in a cycle that shifts the order register.
- R7: In each `z_win` cycle of phase 2'b00 or 2'b10, `track_sel` shifts toward its top bit. Bit 0 takes the address digit: `pc_digit` in 2'b00, `ir_digit` in 2'b10. After six digits, bit 0 holds the last digit and bit 5 the first. In every other cycle, `track_sel` holds its value.
- R8: In each `x_win` cycle of phase 2'b10, `order_reg` shifts the same way, with `ir_digit` entering bit 0. At any other time, only `start_pulse` can change it. An order whose third digit in time is 0 leaves the run bit clear, so the machine is blocked after execute.
- R9: In phase 2'b01, during `w_win`, `pc_next_digit` carries the address field plus one, least significant digit first. Each digit is inverted up to and including the first 0 digit, and all-ones wraps to zero. In every other cycle, `pc_next_digit` equals `pc_digit` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digit clock |
| rst | input | 1 | Synchronous active-high reset |
| t_strobe | input | 1 | Last digit of the word period |
| u_win | input | 1 | Sector-field digit window |
| z_win | input | 1 | Track-field digit window |
| x_win | input | 1 | Order-field digit window |
| w_win | input | 1 | Whole address-field window (sector and track) |
| ann_digit | input | 1 | Serial sector number announced for the next word |
| pc_digit | input | 1 | Serial program-counter digit |
| ir_digit | input | 1 | Serial instruction-register digit |
| start_pulse | input | 1 | Sets the run bit |
| phase | output | 2 | Current phase code |
| track_sel | output | 6 | Track-select shift register |
| order_reg | output | 4 | Order shift register; bit 1 is the run bit |
| pc_next_digit | output | 1 | Serial counter digit to recirculate, incremented in read-instruction |
| blocked | output | 1 | Machine held in seek-instruction |

## Verification
All registered results are due on the clock edge that closes the cycle with the stimulus. `phase` moves on the edge after `t_strobe`. `track_sel` and `order_reg` take a new digit on the edge after each window cycle. `blocked` drops on the edge after `start_pulse`. `pc_next_digit` is combinational from `pc_digit` and the search flag, so it is due in the same cycle as its input digit.

The bench changes its inputs on the falling edge and samples 2 ns later. At that point every registered output reflects all rising edges so far, and `pc_next_digit` reflects the digit just driven. Each cycle, a word-level model pushes the values due into the scoreboard queue. The model judges the search by comparing whole sector numbers, not digit by digit.

// File: rtl/drum_seq_pkg.sv
package drum_seq_pkg;

    typedef enum logic [1:0] {
        PH_SEEK_INSTR = 2'b00,
        PH_READ_INSTR = 2'b01,
        PH_SEEK_OPND  = 2'b10,
        PH_EXECUTE    = 2'b11
    } phase_e;

    localparam int TRACK_DIGITS = 6;
    localparam int ORDER_DIGITS = 4;
    localparam int RUN_STAGE    = 1;

endpackage

// File: rtl/seq_search_flag.sv
module seq_search_flag (
    input  logic clk,
    input  logic rst,
    input  logic word_end,
    input  logic cmp_en,
    input  logic ann_digit,
    input  logic addr_digit,
    input  logic inc_en,
    input  logic cnt_digit,
    output logic k_flag
);

    always_ff @(posedge clk) begin
        if (rst)
            k_flag <= 1'b0;
        else if (word_end)
            k_flag <= 1'b1;
        else if (cmp_en && (ann_digit != addr_digit))
            k_flag <= 1'b0;
        else if (inc_en && !cnt_digit)
            k_flag <= 1'b0;
    end

    AST_FLAG_ARMED_AT_T: assert property (@(posedge clk) disable iff (rst)
        word_end |=> k_flag);                                   // R4

    AST_FLAG_CLEAR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!k_flag && !word_end) |=> !k_flag);                    // R5

endmodule

// File: rtl/seq_shift_reg.sv
module seq_shift_reg #(
    parameter int WIDTH     = 6,
    parameter bit HAS_SET   = 1'b0,
    parameter int SET_STAGE = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             din,
    input  logic             set_en,
    output logic [WIDTH-1:0] q
);

    localparam int TOP = WIDTH - 1;

    generate
        if (HAS_SET) begin : g_settable
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (shift_en)
                    q <= {q[TOP-1:0], din};
                else if (set_en)
                    q[SET_STAGE] <= 1'b1;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (shift_en)
                    q <= {q[TOP-1:0], din};
            end
        end
    endgenerate

    AST_SHIFT_HEAD_TAKES_DIGIT: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (q[0] == $past(din)));                     // R7

    AST_SHIFT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !set_en) |=> $stable(q));                 // R8

endmodule

// File: rtl/drum_phase_seq.sv
module drum_phase_seq
    import drum_seq_pkg::*;
#(
    parameter int TRACK_W = TRACK_DIGITS,
    parameter int ORDER_W = ORDER_DIGITS,
    parameter int RUN_BIT = RUN_STAGE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               t_strobe,
    input  logic               u_win,
    input  logic               z_win,
    input  logic               x_win,
    input  logic               w_win,
    input  logic               ann_digit,
    input  logic               pc_digit,
    input  logic               ir_digit,
    input  logic               start_pulse,
    output logic [1:0]         phase,
    output logic [TRACK_W-1:0] track_sel,
    output logic [ORDER_W-1:0] order_reg,
    output logic               pc_next_digit,
    output logic               blocked
);

    phase_e state_q;
    phase_e state_d;

    logic k_flag;
    logic seeking;
    logic addr_digit;
    logic cmp_en;
    logic inc_en;
    logic track_shift;
    logic order_shift;
    logic run_bit;

    assign run_bit = order_reg[RUN_BIT];

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PH_SEEK_INSTR;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_SEEK_INSTR: if (t_strobe && k_flag && run_bit) state_d = PH_READ_INSTR;
            PH_READ_INSTR: if (t_strobe)                      state_d = PH_SEEK_OPND;
            PH_SEEK_OPND:  if (t_strobe && k_flag)            state_d = PH_EXECUTE;
            PH_EXECUTE:    if (t_strobe)                      state_d = PH_SEEK_INSTR;
            default:                                          state_d = PH_SEEK_INSTR;
        endcase
    end

    // Output and control decode
    always_comb begin
        seeking       = (state_q == PH_SEEK_INSTR) || (state_q == PH_SEEK_OPND);
        addr_digit    = (state_q == PH_SEEK_INSTR) ? pc_digit : ir_digit;
        cmp_en        = seeking && u_win;
        track_shift   = seeking && z_win;
        order_shift   = (state_q == PH_SEEK_OPND) && x_win;
        inc_en        = (state_q == PH_READ_INSTR) && w_win;
        pc_next_digit = (inc_en && k_flag) ? ~pc_digit : pc_digit;
        phase         = state_q;
        blocked       = ~run_bit;
    end

    seq_search_flag u_search (
        .clk        (clk),
        .rst        (rst),
        .word_end   (t_strobe),
        .cmp_en     (cmp_en),
        .ann_digit  (ann_digit),
        .addr_digit (addr_digit),
        .inc_en     (inc_en),
        .cnt_digit  (pc_digit),
        .k_flag     (k_flag)
    );

    seq_shift_reg #(
        .WIDTH     (TRACK_W),
        .HAS_SET   (1'b0),
        .SET_STAGE (0)
    ) u_track (
        .clk      (clk),
        .rst      (rst),
        .shift_en (track_shift),
        .din      (addr_digit),
        .set_en   (1'b0),
        .q        (track_sel)
    );

    seq_shift_reg #(
        .WIDTH     (ORDER_W),
        .HAS_SET   (1'b1),
        .SET_STAGE (RUN_BIT)
    ) u_order (
        .clk      (clk),
        .rst      (rst),
        .shift_en (order_shift),
        .din      (ir_digit),
        .set_en   (start_pulse),
        .q        (order_reg)
    );

    AST_PHASE_ONLY_AT_T: assert property (@(posedge clk) disable iff (rst)
        !t_strobe |=> (phase == $past(phase)));                                  // R2

    AST_READ_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b01 && t_strobe) |=> (phase == 2'b10));                      // R3

    AST_EXEC_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b11 && t_strobe) |=> (phase == 2'b00));                      // R3

    AST_BLOCKED_HOLDS_SEEK: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b00 && blocked) |=> (phase == 2'b00));                       // R6

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && !(phase == 2'b10 && x_win)) |=> !blocked);               // R6

    AST_OPND_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b10 && t_strobe && !k_flag) |=> (phase == 2'b10));           // R5

    AST_COUNTER_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        !(phase == 2'b01 && w_win) |-> (pc_next_digit == pc_digit));            // R9

endmodule

// File: tb/drum_phase_seq_tb_top.sv
module drum_phase_seq_tb_top;
    import drum_seq_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic t_s = 1'b0, u_w = 1'b0, z_w = 1'b0, x_w = 1'b0, w_w = 1'b0;
    logic ann = 1'b0, pcd = 1'b0, ird = 1'b0, start = 1'b0;
    logic [1:0] phase;
    logic [5:0] track_sel;
    logic [3:0] order_reg;
    logic       pc_next_digit;
    logic       blocked;

    drum_phase_seq dut_i (
        .clk           (clk),
        .rst           (rst),
        .t_strobe      (t_s),
        .u_win         (u_w),
        .z_win         (z_w),
        .x_win         (x_w),
        .w_win         (w_w),
        .ann_digit     (ann),
        .pc_digit      (pcd),
        .ir_digit      (ird),
        .start_pulse   (start),
        .phase         (phase),
        .track_sel     (track_sel),
        .order_reg     (order_reg),
        .pc_next_digit (pc_next_digit),
        .blocked       (blocked)
    );

    typedef struct {
        bit         in_rst;
        string      ph_req;
        logic [1:0] ph;
        logic [5:0] trk;
        logic [3:0] ord;
        logic       blk;
        logic       pcn;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // Drum and word-level reference model
    int         digit = 0;
    int         sector = 60;
    int         instr_done = 0;
    int         blk_words = 0;
    logic [11:0] pc_addr = {6'h0A, 6'h3F};
    logic [11:0] ir_addr = '0;
    logic [3:0]  ir_ord  = '0;
    phase_e      m_phase = PH_SEEK_INSTR;
    logic [5:0]  m_track = '0;
    logic [3:0]  m_order = '0;
    bit          m_kvalid = 1'b0;
    bit          m_match  = 1'b0;
    logic [11:0] prog_addr [3];
    logic [3:0]  prog_ord  [3];

    task automatic check1(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, expv, $time);
        end
    endtask

    // Monitor: pops one expected record per cycle and compares
    always @(negedge clk) begin
        exp_t e;
        #2;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check1(e.in_rst ? "R1" : e.ph_req, "phase",     int'(phase),         int'(e.ph));
            check1(e.in_rst ? "R1" : "R7",     "track_sel", int'(track_sel),     int'(e.trk));
            check1(e.in_rst ? "R1" : "R8",     "order_reg", int'(order_reg),     int'(e.ord));
            check1(e.in_rst ? "R1" : "R6",     "blocked",   int'(blocked),       int'(e.blk));
            check1(e.in_rst ? "R1" : "R9",     "pc_next",   int'(pc_next_digit), int'(e.pcn));
        end
    end

    // Driver: drives one digit, pushes the values due, advances the model
    task automatic run_cycle(input bit rv);
        exp_t        e;
        logic [5:0]  ann_sec;
        logic [11:0] pc_inc;
        logic        tv, uv, zv, xv, wv, av, pv, iv, sv;
        @(negedge clk);
        ann_sec = 6'((sector + 1) % 64);
        pc_inc  = pc_addr + 12'd1;
        if (!rv && digit == 0)
            m_match = (ann_sec == ((m_phase == PH_SEEK_INSTR) ? pc_addr[5:0] : ir_addr[5:0]));
        tv = !rv && (digit == 31);
        uv = !rv && (digit >= 1)  && (digit <= 6);
        zv = !rv && (digit >= 7)  && (digit <= 12);
        wv = !rv && (digit >= 1)  && (digit <= 12);
        xv = !rv && (digit >= 13) && (digit <= 16);
        av = uv ? ann_sec[(digit - 1) % 6] : 1'b0;
        pv = wv ? pc_addr[(digit - 1) % 12] : 1'b0;
        iv = wv ? ir_addr[(digit - 1) % 12] : (xv ? ir_ord[(digit - 13) % 4] : 1'b0);
        sv = !rv && (m_phase == PH_SEEK_INSTR) && !m_order[1] && (blk_words >= 3) && (digit == 10);
        rst = rv; t_s = tv; u_w = uv; z_w = zv; x_w = xv; w_w = wv;
        ann = av; pcd = pv; ird = iv; start = sv;

        e.in_rst = rv;
        if (digit != 0)                     e.ph_req = "R2";
        else if (m_phase == PH_SEEK_INSTR)  e.ph_req = m_order[1] ? "R4" : "R6";
        else if (m_phase == PH_SEEK_OPND)   e.ph_req = "R5";
        else                                e.ph_req = "R3";
        e.ph  = m_phase;
        e.trk = m_track;
        e.ord = m_order;
        e.blk = ~m_order[1];
        e.pcn = (m_phase == PH_READ_INSTR && wv) ? pc_inc[(digit - 1) % 12] : pv;
        exp_q.push_back(e);

        if (rv) begin
            m_phase = PH_SEEK_INSTR; m_track = '0; m_order = '0; m_kvalid = 1'b0;
        end else begin
            if (m_phase == PH_SEEK_OPND && xv) m_order = {m_order[2:0], iv};
            else if (sv) begin m_order[1] = 1'b1; blk_words = 0; end
            if (zv && (m_phase == PH_SEEK_INSTR || m_phase == PH_SEEK_OPND))
                m_track = {m_track[4:0], (m_phase == PH_SEEK_INSTR) ? pv : iv};
            if (tv) begin
                case (m_phase)
                    PH_SEEK_INSTR: begin
                        if (m_kvalid && m_match && m_order[1]) m_phase = PH_READ_INSTR;
                        else if (!m_order[1]) blk_words++;
                    end
                    PH_READ_INSTR: begin
                        m_phase = PH_SEEK_OPND;
                        pc_addr = pc_addr + 12'd1;
                        ir_addr = prog_addr[instr_done];
                        ir_ord  = prog_ord[instr_done];
                    end
                    PH_SEEK_OPND: if (m_kvalid && m_match) m_phase = PH_EXECUTE;
                    default: begin
                        m_phase = PH_SEEK_INSTR;
                        instr_done++;
                        if (instr_done == 2) pc_addr = 12'hFFF;   // R9 wrap case next
                    end
                endcase
                m_kvalid = 1'b1;
                sector = (sector + 1) % 64;
            end
            digit = (digit + 1) % 32;
        end
    endtask

    initial begin
        int cyc;
        prog_addr[0] = {6'h15, 6'd10}; prog_ord[0] = 4'b0110;  // third digit 1: keeps running
        prog_addr[1] = {6'h2A, 6'd9};  prog_ord[1] = 4'b0011;  // third digit 0: blocks (R8)
        prog_addr[2] = {6'h3F, 6'd0};  prog_ord[2] = 4'b1101;
        for (int i = 0; i < 3; i++) run_cycle(1'b1);           // R1 reset state
        cyc = 0;
        while (instr_done < 3 && cyc < 100000) begin
            run_cycle(1'b0);
            cyc++;
        end
        check1("R3", "instructions completed", instr_done, 3);
        @(negedge clk);
        @(negedge clk);
        #5;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule